// File: doc/BRIEF.md
# Single-Channel Block Copy Engine

This block moves a programmed number of 16-bit or 32-bit units from a source address to a destination address. It talks to memory over a synchronous port whose read data comes back one cycle after the request. Software writes four program registers through a small write port: source, destination, a 16-bit unit count and a 16-bit control word. Setting the enable bit latches the source, destination and count into the working registers. The transfer then starts at once, or waits for one of three external start strobes.

Each unit takes one read cycle followed by one write cycle. The source and destination addresses each step by their own mode. On repeat, the count can reload, and so can the destination, so that a periodic transfer refills a fixed window. A one-cycle interrupt pulse can mark the end of each transfer. The channel's position among its siblings is a parameter. It sets the unit count used when the programmed count is zero.

Top module: `dma_chan_engine`

## Requirements
- R1: A write to the control register (prog_sel = 3) that moves bit 15 from 0 to 1 while idle latches the programmed source, destination and count into the working registers. If bits 13:12 of the written value are 0, the first read request appears in the cycle after that write.
- R2: Each unit is a read cycle (mem_req=1, mem_we=0, mem_addr = working source) followed directly by a write cycle (mem_req=1, mem_we=1, mem_addr = working destination). In the write cycle, mem_wdata equals the mem_rdata returned for that read.
- R3: Control bits 6:5 set the destination step after each unit: 0 adds the unit size, 1 subtracts it, 2 holds, and 3 adds it and returns to the programmed destination when a repeat reloads.
- R4: Control bits 8:7 set the source step after each unit: 0 adds the unit size, 1 subtracts it, and both 2 and 3 hold the address.
- R5: Control bit 10 selects 32-bit units (mem_word=1, step 4) when set and 16-bit units (mem_word=0, step 2) when clear.
- R6: Issued addresses have bits 1:0 cleared for 32-bit units and bit 0 cleared for 16-bit units, and stepping continues from the aligned address.
- R7: A programmed count of 0 stands for MAX_CNT_LAST units when CHAN_ID equals CHAN_LAST, and for MAX_CNT_OTHER units otherwise.
- R8: When control bit 14 is set, irq is high for exactly one cycle, in the cycle after the last unit's write. When bit 14 is clear, irq stays low.
- R9: At completion, bit 15 of ctrl_rd clears if bit 9 (repeat) is 0 or bits 13:12 are 0. Otherwise it stays set.
- R10: On a repeat, the count reloads from the programmed count and the working source carries on from where it stopped. The destination also carries on, unless its mode is 3.
- R11: With bits 13:12 equal to 1, 2 or 3, a transfer starts only on a trig_vblank, trig_hblank or trig_special pulse respectively, while enabled and idle. Non-matching strobes, and strobes that arrive while a transfer is running, start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_we | input | 1 | Program register write strobe |
| prog_sel | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 control |
| prog_wdata | input | ADDR_W | Write data (count and control use the low 16 bits) |
| ctrl_rd | output | 16 | Current control word |
| trig_vblank | input | 1 | Start strobe for timing code 1 |
| trig_hblank | input | 1 | Start strobe for timing code 2 |
| trig_special | input | 1 | Start strobe for timing code 3 |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 write, 0 read |
| mem_word | output | 1 | 1 for a 32-bit access, 0 for 16-bit |
| mem_addr | output | ADDR_W | Access address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid one cycle after the read request |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Completion interrupt pulse |

## Verification
The bench builds two instances: one with CHAN_ID equal to CHAN_LAST and MAX_CNT_LAST set to 12, and one with CHAN_ID below CHAN_LAST and MAX_CNT_OTHER set to 6. With these small limits, both meanings of a zero count finish in a few dozen cycles and are counted unit by unit. The bench sweeps all sixteen source and destination step pairs at both unit sizes, each from a misaligned start. Repeat sequences cover the destination reload, the carried-on source, and which strobes are ignored.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} dma_state_e;

  localparam int CB_DSTEP = 5;
  localparam int CB_SSTEP = 7;
  localparam int CB_REPEAT = 9;
  localparam int CB_WORD = 10;
  localparam int CB_TIME = 12;
  localparam int CB_IRQ = 14;
  localparam int CB_EN = 15;

  localparam logic [1:0] SEL_SRC = 2'd0;
  localparam logic [1:0] SEL_DST = 2'd1;
  localparam logic [1:0] SEL_CNT = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;
endpackage

// File: rtl/dma_addr_unit.sv
module dma_addr_unit #(
  parameter int ADDR_W = 32,
  parameter bit IS_DST = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              rewind,
  input  logic [ADDR_W-1:0] rewind_val,
  input  logic              adv,
  input  logic [1:0]        mode,
  input  logic              word,
  output logic [ADDR_W-1:0] cur_addr
);
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] next_addr;

  function automatic logic [ADDR_W-1:0] align_addr(input logic [ADDR_W-1:0] a, input logic w);
    return w ? {a[ADDR_W-1:2], 2'b00} : {a[ADDR_W-1:1], 1'b0};
  endfunction

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                  input logic [1:0] m, input logic w);
    logic [ADDR_W-1:0] sz;
    sz = w ? ADDR_W'(4) : ADDR_W'(2);
    case (m)
      2'd0: return a + sz;
      2'd1: return a - sz;
      2'd2: return a;
      default: return IS_DST ? a + sz : a;
    endcase
  endfunction

  assign cur_addr  = align_addr(addr_q, word);
  assign next_addr = step_addr(cur_addr, mode, word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (load)   addr_q <= load_val;
    else if (rewind) addr_q <= rewind_val;
    else if (adv)    addr_q <= next_addr;
  end

  // R3 R4
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && !rewind && mode == 2'd2) |=> (addr_q == $past(cur_addr)));
endmodule

// File: rtl/dma_unit_counter.sv
module dma_unit_counter #(
  parameter int CW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          last
);
  logic [CW-1:0] rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rem_q <= '0;
    else if (load) rem_q <= load_val;
    else if (dec)  rem_q <= rem_q - 1'b1;
  end

  assign last = (rem_q == CW'(1));

  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (rem_q != '0));
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CHAN_ID = 0,
  parameter int CHAN_LAST = 3,
  parameter int MAX_CNT_LAST = 65536,
  parameter int MAX_CNT_OTHER = 16384
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_we,
  input  logic [1:0]        prog_sel,
  input  logic [ADDR_W-1:0] prog_wdata,
  output logic [15:0]       ctrl_rd,
  input  logic              trig_vblank,
  input  logic              trig_hblank,
  input  logic              trig_special,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_word,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              irq
);
  localparam int MAX_CNT = (CHAN_ID == CHAN_LAST) ? MAX_CNT_LAST : MAX_CNT_OTHER;
  localparam int NEED_W = $clog2(MAX_CNT + 1);
  localparam int CW = (NEED_W > 16) ? NEED_W : 17;

  logic [ADDR_W-1:0] src_prog, dst_prog;
  logic [15:0]       cnt_prog, ctrl_q;
  dma_state_e        state_q;
  logic              irq_q;

  logic ctrl_wr, en_latch, start_imm, trig_hit, start;
  logic unit_done, cnt_last, last_unit, keep_en, cnt_load;
  logic [1:0] timing;
  logic [CW-1:0] cnt_val;
  logic [ADDR_W-1:0] src_cur, dst_cur;

  assign timing    = ctrl_q[CB_TIME+:2];
  assign ctrl_wr   = prog_we && (prog_sel == SEL_CTRL);
  assign en_latch  = ctrl_wr && prog_wdata[CB_EN] && !ctrl_q[CB_EN] && (state_q == ST_IDLE);
  assign start_imm = en_latch && (prog_wdata[CB_TIME+:2] == 2'd0);
  assign trig_hit  = ctrl_q[CB_EN] && (state_q == ST_IDLE) && !ctrl_wr &&
                     (((timing == 2'd1) && trig_vblank) ||
                      ((timing == 2'd2) && trig_hblank) ||
                      ((timing == 2'd3) && trig_special));
  assign start     = start_imm || trig_hit;
  assign unit_done = (state_q == ST_WR);
  assign last_unit = unit_done && cnt_last;
  assign keep_en   = ctrl_q[CB_REPEAT] && (timing != 2'd0);
  assign cnt_load  = en_latch || (last_unit && keep_en);
  assign cnt_val   = (cnt_prog == 16'd0) ? CW'(MAX_CNT) : CW'(cnt_prog);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_prog <= '0;
      dst_prog <= '0;
      cnt_prog <= '0;
    end else if (prog_we) begin
      case (prog_sel)
        SEL_SRC: src_prog <= prog_wdata;
        SEL_DST: dst_prog <= prog_wdata;
        SEL_CNT: cnt_prog <= prog_wdata[15:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   ctrl_q <= '0;
    else if (ctrl_wr)             ctrl_q <= prog_wdata[15:0];
    else if (last_unit && !keep_en) ctrl_q[CB_EN] <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= last_unit && ctrl_q[CB_IRQ];
      case (state_q)
        ST_IDLE: if (start) state_q <= ST_RD;
        ST_RD:   state_q <= ST_WR;
        default: state_q <= cnt_last ? ST_IDLE : ST_RD;
      endcase
    end
  end

  dma_addr_unit #(.ADDR_W(ADDR_W), .IS_DST(1'b0)) u_src (
    .clk(clk), .rst_n(rst_n), .load(en_latch), .load_val(src_prog),
    .rewind(1'b0), .rewind_val(src_prog), .adv(unit_done),
    .mode(ctrl_q[CB_SSTEP+:2]), .word(ctrl_q[CB_WORD]), .cur_addr(src_cur));

  dma_addr_unit #(.ADDR_W(ADDR_W), .IS_DST(1'b1)) u_dst (
    .clk(clk), .rst_n(rst_n), .load(en_latch), .load_val(dst_prog),
    .rewind(last_unit && keep_en && (ctrl_q[CB_DSTEP+:2] == 2'd3)),
    .rewind_val(dst_prog), .adv(unit_done),
    .mode(ctrl_q[CB_DSTEP+:2]), .word(ctrl_q[CB_WORD]), .cur_addr(dst_cur));

  dma_unit_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val),
    .dec(unit_done), .last(cnt_last));

  assign mem_req   = (state_q != ST_IDLE);
  assign mem_we    = (state_q == ST_WR);
  assign mem_word  = ctrl_q[CB_WORD];
  assign mem_addr  = (state_q == ST_WR) ? dst_cur : src_cur;
  assign mem_wdata = mem_rdata;
  assign busy      = (state_q != ST_IDLE);
  assign irq       = irq_q;
  assign ctrl_rd   = ctrl_q;

  // R2
  write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> $past(mem_req && !mem_we));
  // R6
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_word) |-> (mem_addr[1:0] == 2'b00));
  // R8
  irq_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(mem_req && mem_we));
  // R9
  en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_unit && !keep_en && !ctrl_wr) |=> !ctrl_rd[CB_EN]);
  // R11
  no_early_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !mem_req);
endmodule

// File: tb/sim_dma_chan_engine.sv
module sim_dma_chan_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        prog_we = 1'b0;
  logic [1:0]  prog_sel = 2'd0;
  logic [31:0] prog_wdata = '0;
  logic        tv = 1'b0, th = 1'b0, ts = 1'b0;

  logic [15:0] ctrl0, ctrl1;
  logic        req0, we0, word0, busy0, irq0;
  logic        req1, we1, word1, busy1, irq1;
  logic [31:0] addr0, wd0, addr1, wd1;
  logic [31:0] rd0 = '0, rd1 = '0;

  function automatic logic [31:0] mem_fn(input logic [31:0] a);
    return a ^ 32'hA5A5_0000;
  endfunction

  always @(posedge clk) begin
    rd0 <= mem_fn(addr0);
    rd1 <= mem_fn(addr1);
  end

  dma_chan_engine #(.CHAN_ID(3), .CHAN_LAST(3), .MAX_CNT_LAST(12), .MAX_CNT_OTHER(6)) u0 (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_sel(prog_sel), .prog_wdata(prog_wdata),
    .ctrl_rd(ctrl0), .trig_vblank(tv), .trig_hblank(th), .trig_special(ts),
    .mem_req(req0), .mem_we(we0), .mem_word(word0), .mem_addr(addr0), .mem_wdata(wd0),
    .mem_rdata(rd0), .busy(busy0), .irq(irq0));

  dma_chan_engine #(.CHAN_ID(1), .CHAN_LAST(3), .MAX_CNT_LAST(12), .MAX_CNT_OTHER(6)) u1 (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_sel(prog_sel), .prog_wdata(prog_wdata),
    .ctrl_rd(ctrl1), .trig_vblank(tv), .trig_hblank(th), .trig_special(ts),
    .mem_req(req1), .mem_we(we1), .mem_word(word1), .mem_addr(addr1), .mem_wdata(wd1),
    .mem_rdata(rd1), .busy(busy1), .irq(irq1));

  logic [31:0] rda [0:1023];
  logic [31:0] wra [0:1023];
  logic [31:0] wrd [0:1023];
  int rd_n = 0, wr_n = 0, irq_n = 0, rd1_n = 0;
  int n_chk = 0, n_fail = 0;

  always @(negedge clk) begin
    if (req0 && !we0 && rd_n < 1024) begin rda[rd_n] = addr0; rd_n++; end
    if (req0 && we0 && wr_n < 1024) begin wra[wr_n] = addr0; wrd[wr_n] = wd0; wr_n++; end
    if (irq0) irq_n++;
    if (req1 && !we1) rd1_n++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [31:0] v);
    @(negedge clk);
    prog_we = 1'b1; prog_sel = sel; prog_wdata = v;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic wait_idle();
    int t = 0;
    while ((busy0 || busy1) && t < 2000) begin @(negedge clk); t++; end
    if (t >= 2000) chk(1'b0, "watchdog", 32'(t), 32'd0);
    @(negedge clk);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 1) tv = 1'b1; else if (which == 2) th = 1'b1; else ts = 1'b1;
    @(negedge clk);
    tv = 1'b0; th = 1'b0; ts = 1'b0;
  endtask

  function automatic logic [31:0] exp_addr(input logic [31:0] base, input int mode, input bit w,
                                           input int k, input bit is_src);
    logic [31:0] b, s;
    b = w ? (base & 32'hFFFF_FFFC) : (base & 32'hFFFF_FFFE);
    s = w ? 32'd4 : 32'd2;
    if (mode == 0) return b + 32'(k) * s;
    if (mode == 1) return b - 32'(k) * s;
    if (mode == 2) return b;
    return is_src ? b : b + 32'(k) * s;
  endfunction

  task automatic check_units(input int b, input int n, input logic [31:0] sb, input int sm,
                             input int sk, input logic [31:0] db, input int dm, input int dk,
                             input bit w, input string req);
    bit ok = 1'b1;
    logic [31:0] act = '0, exp = '0;
    for (int i = 0; i < n; i++) begin
      logic [31:0] es, ed;
      es = exp_addr(sb, sm, w, sk + i, 1'b1);
      ed = exp_addr(db, dm, w, dk + i, 1'b0);
      if (ok && rda[b+i] !== es) begin ok = 1'b0; act = rda[b+i]; exp = es; end
      if (ok && wra[b+i] !== ed) begin ok = 1'b0; act = wra[b+i]; exp = ed; end
      if (ok && wrd[b+i] !== mem_fn(es)) begin ok = 1'b0; act = wrd[b+i]; exp = mem_fn(es); end
    end
    chk(ok, req, act, exp);
  endtask

  initial begin
    int b, ib, b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!req0 && !busy0 && !irq0 && ctrl0 == 16'h0, "R1 reset", {req0, busy0, irq0, 13'd0, ctrl0}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5 R6 R8 R9 sweep of step modes and sizes from misaligned starts
    for (int w = 0; w < 2; w++) begin
      for (int sm = 0; sm < 4; sm++) begin
        for (int dm = 0; dm < 4; dm++) begin
          logic [31:0] sa, da;
          sa = 32'h1000_0103 + 32'((w * 16 + sm * 4 + dm) << 8);
          da = 32'h2000_0802 + 32'((w * 16 + sm * 4 + dm) << 8);
          wr_reg(2'd0, sa);
          wr_reg(2'd1, da);
          wr_reg(2'd2, 32'd3);
          b = wr_n; ib = irq_n;
          wr_reg(2'd3, 32'h0000_C000 | 32'(w << 10) | 32'(sm << 7) | 32'(dm << 5));
          wait_idle();
          chk(wr_n - b == 3 && rd_n == wr_n, "R2 unit count", 32'(wr_n - b), 32'd3);
          check_units(b, 3, sa, sm, 0, da, dm, 0, w[0], "R3 R4 R5 R6 addresses and data");
          chk(irq_n - ib == 1, "R8 one irq", 32'(irq_n - ib), 32'd1);
          chk(ctrl0[15] == 1'b0, "R9 enable cleared", {16'd0, ctrl0}, 32'd0);
        end
      end
    end

    // R11 R10 R9 repeat with vblank timing, dest mode 3
    wr_reg(2'd0, 32'h3000_0000);
    wr_reg(2'd1, 32'h4000_0000);
    wr_reg(2'd2, 32'd2);
    b = wr_n;
    wr_reg(2'd3, 32'h0000_D660);
    repeat (4) @(negedge clk);
    chk(wr_n == b && !busy0, "R11 no start without strobe", 32'(wr_n - b), 32'd0);
    pulse(2);
    repeat (4) @(negedge clk);
    chk(wr_n == b && !busy0, "R11 wrong strobe ignored", 32'(wr_n - b), 32'd0);
    pulse(1);
    wait_idle();
    chk(wr_n - b == 2, "R11 vblank starts", 32'(wr_n - b), 32'd2);
    check_units(b, 2, 32'h3000_0000, 0, 0, 32'h4000_0000, 3, 0, 1'b1, "R1 first pass");
    chk(ctrl0[15] == 1'b1, "R9 enable kept on repeat", {16'd0, ctrl0}, 32'h8000);
    b = wr_n;
    pulse(1);
    wait_idle();
    chk(wr_n - b == 2, "R10 count reload", 32'(wr_n - b), 32'd2);
    check_units(b, 2, 32'h3000_0000, 0, 2, 32'h4000_0000, 3, 0, 1'b1, "R10 dest reload src continues");

    // R10 repeat with hblank timing, dest mode 0 continues
    wr_reg(2'd3, 32'h0);
    b = wr_n;
    wr_reg(2'd3, 32'h0000_A600);
    pulse(2);
    wait_idle();
    pulse(2);
    wait_idle();
    chk(wr_n - b == 4, "R10 two passes", 32'(wr_n - b), 32'd4);
    check_units(b, 4, 32'h3000_0000, 0, 0, 32'h4000_0000, 0, 0, 1'b1, "R10 dest continues");

    // R9 R8 immediate with repeat bit clears enable, irq off
    wr_reg(2'd3, 32'h0);
    b = wr_n; ib = irq_n;
    wr_reg(2'd3, 32'h0000_8600);
    wait_idle();
    chk(wr_n - b == 2, "R1 immediate start", 32'(wr_n - b), 32'd2);
    chk(ctrl0[15] == 1'b0, "R9 immediate clears enable", {16'd0, ctrl0}, 32'd0);
    chk(irq_n == ib, "R8 no irq when bit 14 clear", 32'(irq_n - ib), 32'd0);

    // R11 special strobe, second strobe while busy ignored
    wr_reg(2'd2, 32'd3);
    b = wr_n;
    wr_reg(2'd3, 32'h0000_B400);
    pulse(3);
    pulse(3);
    wait_idle();
    pulse(3);
    repeat (4) @(negedge clk);
    chk(wr_n - b == 3, "R11 strobe while busy ignored", 32'(wr_n - b), 32'd3);
    chk(ctrl0[15] == 1'b0, "R9 non-repeat clears", {16'd0, ctrl0}, 32'd0);

    // R7 zero count
    wr_reg(2'd2, 32'd0);
    b = wr_n; b1 = rd1_n;
    wr_reg(2'd3, 32'h0000_8400);
    wait_idle();
    chk(wr_n - b == 12, "R7 last channel max", 32'(wr_n - b), 32'd12);
    chk(rd1_n - b1 == 6, "R7 other channel max", 32'(rd1_n - b1), 32'd6);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule